// File: doc/BRIEF.md
# Push-Button Serial Message Transmitter

This block sends a fixed ASCII text line out of an asynchronous serial transmit pin every time a push button is pressed. The button input is raw and asynchronous: it is synchronized to the system clock, and only its rising edge starts a message. The message is the six bytes `TEST` followed by carriage return and line feed.

Bit timing comes from a fractional accumulator that runs in the system clock domain. No divided clock is used. The accumulator issues a one-cycle bit tick. Over any span of `CLK_HZ` cycles it issues exactly `BAUD_HZ` ticks, so the average bit rate is exact even when the clock-to-baud ratio is not an integer.

Characters are sent back to back with one start bit, eight data bits and one stop bit. A sequencer walks the message from start to end and ignores any further press until the last stop bit has finished. A 4-bit LED output counts the completed messages.

Top module: `btn_msg_uart_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `tx` is high (idle) and `led` is 0.
- R2: The bit accumulator always holds a value in [0, CLK_HZ). On each clock, if its value is below BAUD_HZ, the next cycle carries a tick and CLK_HZ-BAUD_HZ is added; otherwise there is no tick and BAUD_HZ is subtracted.
- R3: Ticks come at an exact average rate. No gap between ticks exceeds ceil(CLK_HZ/BAUD_HZ) cycles. Start-bit edges of consecutive characters in a message lie within 1.5 clock cycles of their ideal spacing of 10 nominal bit periods, including for non-integer ratios.
- R4: The button passes through a two-flop synchronizer. A message starts only on a rising edge of the synchronized level. Holding the button produces exactly one message, and after release a new press starts a new message.
- R5: A message is the bytes 0x54, 0x45, 0x53, 0x54, 0x0D, 0x0A, sent in that order.
- R6: Each byte is framed as a low start bit, then data bits 0 to 7 (LSB first), then a high stop bit. Frames within a message follow each other with no idle gap. The line is high whenever no frame is being sent.
- R7: `tx` changes only in the cycle after a bit tick, and a frame begins by driving `tx` low.
- R8: A press that arrives while a message is in progress neither restarts nor extends it, and it does not cause a second message afterwards.
- R9: `led` counts completed messages modulo 16. It increases by exactly one after the final stop bit of each message ends, and never changes otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous push-button level |
| tx | output | 1 | Serial transmit line, idles high |
| led | output | 4 | Completed-message count modulo 16 |

## Verification
A corrupted accumulator shows up as frames that drift against the nominal bit period. Within one character the mid-bit samples slide into neighbouring bits, and across a message the start-edge times wander away from multiples of ten bit periods. The bench decodes a fractional-ratio instance so that this drift is caught within a few frames. A wrong message index or shift-register state appears in the very next decoded byte. A sequencer that fails to ignore presses shows up as extra frames on a line that should stay idle, or as an LED count that jumps by more than one, within one message time.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;

    localparam int DATA_W   = 8;
    localparam int MSG_LEN  = 6;
    localparam int IDX_W    = $clog2(MSG_LEN);
    localparam int LEFT_W   = $clog2(DATA_W + 2);
    localparam int LED_W    = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SEND  = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              active;
        logic [LEFT_W-1:0] left;
        logic [DATA_W:0]   bits;   // data bits then stop bit, LSB sent first
    } ser_state_t;

    function automatic logic [DATA_W-1:0] msg_char(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    msg_char = 8'h54;
            3'd1:    msg_char = 8'h45;
            3'd2:    msg_char = 8'h53;
            3'd3:    msg_char = 8'h54;
            3'd4:    msg_char = 8'h0D;
            default: msg_char = 8'h0A;
        endcase
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press
);
    logic [STAGES-1:0] chain;
    logic              last_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '0;
            last_lvl <= 1'b0;
        end else begin
            chain    <= {chain[STAGES-2:0], btn_raw};
            last_lvl <= chain[STAGES-1];
        end
    end

    assign press = chain[STAGES-1] & ~last_lvl;
endmodule

// File: rtl/baud_accum.sv
module baud_accum #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int BAUD_HZ = 115_200,
    localparam int ACC_W  = $clog2(CLK_HZ) + 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             tick,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] STEP_DN = ACC_W'(BAUD_HZ);
    localparam logic [ACC_W-1:0] STEP_UP = ACC_W'(CLK_HZ - BAUD_HZ);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (acc < STEP_DN) begin
            acc  <= acc + STEP_UP;
            tick <= 1'b1;
        end else begin
            acc  <= acc - STEP_DN;
            tick <= 1'b0;
        end
    end

    assign acc_o = acc;
endmodule

// File: rtl/uart_ser.sv
module uart_ser
    import msg_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              busy,
    output logic              tx
);
    localparam logic [LEFT_W-1:0] LOAD_LEFT = LEFT_W'(DATA_W + 1);

    ser_state_t st;
    logic       frame_free;

    assign frame_free = !st.active || (st.left == '0);
    assign take       = tick && frame_free && avail;
    assign busy       = st.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.active <= 1'b0;
            st.left   <= '0;
            st.bits   <= '1;
            tx        <= 1'b1;
        end else if (tick) begin
            if (frame_free) begin
                if (avail) begin
                    tx        <= 1'b0;
                    st.bits   <= {1'b1, data};
                    st.left   <= LOAD_LEFT;
                    st.active <= 1'b1;
                end else begin
                    tx        <= 1'b1;
                    st.active <= 1'b0;
                end
            end else begin
                tx      <= st.bits[0];
                st.bits <= {1'b1, st.bits[DATA_W:1]};
                st.left <= st.left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/msg_seq.sv
module msg_seq
    import msg_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              press,
    input  logic              take,
    input  logic              ser_busy,
    output logic              avail,
    output logic [DATA_W-1:0] data,
    output seq_state_t        state,
    output logic [IDX_W-1:0]  idx,
    output logic [LED_W-1:0]  done_cnt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_LEN - 1);

    assign avail = (state == SEQ_SEND);
    assign data  = msg_char(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            idx      <= '0;
            done_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (press) begin
                    state <= SEQ_SEND;
                    idx   <= '0;
                end
                SEQ_SEND: if (take) begin
                    if (idx == LAST) state <= SEQ_DRAIN;
                    else             idx   <= idx + 1'b1;
                end
                SEQ_DRAIN: if (!ser_busy) begin
                    state    <= SEQ_IDLE;
                    done_cnt <= done_cnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/btn_msg_uart_tx.sv
module btn_msg_uart_tx
    import msg_tx_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int BAUD_HZ     = 115_200,
    parameter int SYNC_STAGES = 2,
    localparam int ACC_W      = $clog2(CLK_HZ) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_raw,
    output logic       tx,
    output logic [3:0] led
);
    logic              press;
    logic              baud_tick;
    logic [ACC_W-1:0]  acc_val;
    logic              ser_take;
    logic              ser_busy;
    logic              seq_avail;
    logic [DATA_W-1:0] seq_data;
    seq_state_t        seq_state;
    logic [IDX_W-1:0]  char_idx;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .press(press)
    );

    baud_accum #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_baud (
        .clk(clk), .rst(rst), .tick(baud_tick), .acc_o(acc_val)
    );

    msg_seq u_seq (
        .clk(clk), .rst(rst), .press(press), .take(ser_take),
        .ser_busy(ser_busy), .avail(seq_avail), .data(seq_data),
        .state(seq_state), .idx(char_idx), .done_cnt(led)
    );

    uart_ser u_ser (
        .clk(clk), .rst(rst), .tick(baud_tick), .avail(seq_avail),
        .data(seq_data), .take(ser_take), .busy(ser_busy), .tx(tx)
    );
endmodule

// File: rtl/msg_tx_chk.sv
module msg_tx_chk
    import msg_tx_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int BAUD_HZ = 115_200,
    localparam int ACC_W  = $clog2(CLK_HZ) + 1,
    localparam int MAXGAP = (CLK_HZ + BAUD_HZ - 1) / BAUD_HZ,
    localparam int GAP_W  = $clog2(MAXGAP + 2) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tx,
    input logic [3:0]       led,
    input logic             tick,
    input logic [ACC_W-1:0] acc,
    input logic             press,
    input logic             busy,
    input seq_state_t       state,
    input logic [IDX_W-1:0] idx,
    input logic             take
);
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || tick)             gap <= '0;
        else if (gap != '1)          gap <= gap + 1'b1;
    end

    a_r2_acc_range: assert property (@(posedge clk) disable iff (rst)
        acc < ACC_W'(CLK_HZ));

    a_r2_tick_rule: assert property (@(posedge clk) disable iff (rst)
        (acc < ACC_W'(BAUD_HZ)) |=> tick);

    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        gap <= GAP_W'(MAXGAP));

    a_r7_tx_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx));

    a_r7_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    a_r8_send_hold: assert property (@(posedge clk) disable iff (rst)
        (press && state == SEQ_SEND && !take) |=> idx == $past(idx));

    a_r8_drain_hold: assert property (@(posedge clk) disable iff (rst)
        (press && state == SEQ_DRAIN) |=> state != SEQ_SEND);

    a_r9_led_step: assert property (@(posedge clk) disable iff (rst)
        (led != $past(led)) |-> (led == $past(led) + 4'd1));
endmodule

bind btn_msg_uart_tx msg_tx_chk #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_chk (
    .clk(clk), .rst(rst), .tx(tx), .led(led), .tick(baud_tick),
    .acc(acc_val), .press(press), .busy(ser_busy), .state(seq_state),
    .idx(char_idx), .take(ser_take)
);

// File: tb/btn_msg_uart_tx_tb.sv
`timescale 1ns/1ps
module btn_msg_uart_tx_tb;
    localparam int CLK_HZ  = 100_000_000;
    localparam int BAUD_N  = 10_000_000;   // integer ratio: 10 cycles per bit
    localparam int BAUD_F  = 3_000_000;    // fractional ratio: 33.33 cycles per bit

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_n = 1'b0;
    logic       btn_f = 1'b0;
    logic       tx_n, tx_f;
    logic [3:0] led_n, led_f;
    logic       sel = 1'b0;
    logic       rx_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_msg [6] = '{8'h54, 8'h45, 8'h53, 8'h54, 8'h0D, 8'h0A};

    always #5 clk = ~clk;

    btn_msg_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_N)) u_dut (
        .clk(clk), .rst(rst), .btn_raw(btn_n), .tx(tx_n), .led(led_n)
    );

    btn_msg_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_F)) u_dut_frac (
        .clk(clk), .rst(rst), .btn_raw(btn_f), .tx(tx_f), .led(led_f)
    );

    assign rx_line = sel ? tx_f : tx_n;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic pulse_btn(input bit which, input int cycles);
        @(negedge clk);
        if (which) btn_f = 1'b1; else btn_n = 1'b1;
        repeat (cycles) @(negedge clk);
        if (which) btn_f = 1'b0; else btn_n = 1'b0;
    endtask

    // decode one message on rx_line at the nominal bit period
    task automatic recv_msg();
        real p;
        real t0;
        real t;
        logic [7:0] d;
        p = sel ? 1.0e9 / BAUD_F : 1.0e9 / BAUD_N;
        t0 = 0.0;
        for (int k = 0; k < 6; k++) begin
            @(negedge rx_line);
            t = $realtime;
            if (k == 0) t0 = t;
            else begin
                // R3: start edges at exact average spacing of 10 bit periods
                chk((t - t0 - k * 10.0 * p) <= 15.0 && (t - t0 - k * 10.0 * p) >= -15.0,
                    "R3 start spacing", int'(t - t0), int'(k * 10.0 * p));
            end
            #(p / 2.0 + 3.0);
            chk(rx_line == 1'b0, "R6 start bit", rx_line, 0);
            for (int b = 0; b < 8; b++) begin
                #(p);
                d[b] = rx_line;
            end
            #(p);
            chk(rx_line == 1'b1, "R6 stop bit", rx_line, 1);
            chk(d == exp_msg[k], "R5 message byte", d, exp_msg[k]);
        end
    endtask

    task automatic idle_watch(input int cycles, input string req);
        int lows;
        lows = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (rx_line !== 1'b1) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(tx_n == 1'b1 && tx_f == 1'b1, "R1 tx idle in reset", {tx_n, tx_f}, 3);
        chk(led_n == 4'd0 && led_f == 4'd0, "R1 led zero in reset", {led_n, led_f}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_n == 1'b1, "R1 tx idle after reset", tx_n, 1);
        sel = 1'b0;
        idle_watch(200, "R6 idle high without press");

        // single press, integer ratio
        fork
            pulse_btn(1'b0, 4);
            recv_msg();
        join
        repeat (40) @(negedge clk);
        chk(led_n == 4'd1, "R9 led after first message", led_n, 1);

        // R8: extra press in mid-message is ignored
        fork
            begin
                pulse_btn(1'b0, 4);
                #(2500);
                pulse_btn(1'b0, 4);
                #(2000);
                pulse_btn(1'b0, 4);
            end
            recv_msg();
        join
        idle_watch(800, "R8 no message from press during sending");
        chk(led_n == 4'd2, "R8 R9 led counts one message", led_n, 2);

        // R4: held button gives exactly one message
        @(negedge clk);
        btn_n = 1'b1;
        recv_msg();
        idle_watch(800, "R4 held button no repeat");
        btn_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(led_n == 4'd3, "R4 led after held press", led_n, 3);
        fork
            pulse_btn(1'b0, 3);
            recv_msg();
        join
        repeat (40) @(negedge clk);
        chk(led_n == 4'd4, "R4 new press after release", led_n, 4);

        // R3: fractional ratio instance
        sel = 1'b1;
        @(negedge clk);
        chk(led_f == 4'd0, "R9 frac led idle", led_f, 0);
        fork
            pulse_btn(1'b1, 4);
            recv_msg();
        join
        repeat (80) @(negedge clk);
        chk(led_f == 4'd1, "R9 frac led after message", led_f, 1);
        fork
            pulse_btn(1'b1, 4);
            recv_msg();
        join
        repeat (80) @(negedge clk);
        chk(led_f == 4'd2, "R3 frac second message", led_f, 2);
        chk(led_n == 4'd4, "R9 other instance unchanged", led_n, 4);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule